// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This engine walks a chain of 8-byte descriptors held in system memory and moves data between that memory and a byte-wide, block-oriented card data port. Data always passes through a staging buffer one block deep. When moving card data to memory, a whole block is pulled from the card whenever the buffer is empty. When moving memory data to the card, bytes collect in the buffer and go to the card as soon as a full block is present. A block that is only partly used at the end of one descriptor carries over into the next descriptor.

Software sets the direction, the block size, the block count mode and count, and the descriptor base address, then pulses `start`. The engine stops in one of four ways. It finishes when the block count runs out or when it reaches an end-flagged descriptor. It stops on an invalid descriptor. It pauses after a descriptor that carries the interrupt flag, and a continue request resumes it. The status word records the final-block event, the interrupt-status event, a length mismatch and the state in which a fault occurred.

Top module: `sgdma_engine`

## Requirements
- R1: A descriptor is fetched as eight one-byte memory reads, at pointer+0 through pointer+7 in that order. Byte 0 holds the attributes: bit 0 valid, bit 1 end, bit 2 interrupt, and bits 5:4 the action (2'b10 transfer, 2'b11 link, any other value no-op). Bytes 3:2 hold the 16-bit length and bytes 7:4 hold the 32-bit data address, both little-endian.
- R2: A length of zero stands for 65536 bytes. Bits 1:0 of the data address are cleared before use.
- R3: A descriptor with the valid bit clear stops the engine without a `xfer_done` pulse. It sets status[1:0] to 2'b01 and, if `err_int_en` is high, raises `err_irq`.
- R4: With `dir_to_mem`=1 and the buffer empty, the engine reads `blk_size` bytes from the card and then writes them to consecutive memory addresses starting at the aligned data address. A partly used block carries over to the next transfer descriptor.
- R5: With `dir_to_mem`=0, bytes are read from consecutive memory addresses into the buffer. Each full block is written to the card in byte order.
- R6: A link descriptor loads its aligned data address into the descriptor pointer. Transfer and no-op descriptors advance the pointer by 8. Non-transfer descriptors move no data and count as having no bytes left.
- R7: Each full block decrements the count when `cnt_mode`=1. The walk finishes when the count reaches zero, or after an end-flagged descriptor, with a one-cycle `xfer_done` pulse and status[10] set.
- R8: A length mismatch sets status[2] and status[1:0]=2'b11, and raises `err_irq` if enabled. It is flagged when the walk finishes in any of three cases: bytes remain in the descriptor, the end flag arrives with a nonzero count in count mode, or the count reaches zero without the end flag.
- R9: An unfinished walk halts after a descriptor with the interrupt flag. `paused` rises, status[8] is set, and `dma_irq` follows status[8] while `dma_int_en`=1.
- R10: A control write with bit 9 set resumes a paused walk at the next descriptor. Resuming clears status[10] and status[2]. The same write has no effect while the engine is idle.
- R11: A control write with bit 8 set clears status[8]. Control writes never set status[8] or status[10].
- R12: Only one memory access is outstanding at a time. `mem_req`, `mem_addr` and `mem_we` hold steady until `mem_ready`. Memory and card strobes are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk at `desc_base` (accepted while idle or paused) |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 11 | Control data: bit 8 clears interrupt status, bit 9 requests continue |
| dir_to_mem | input | 1 | 1: card to memory, 0: memory to card |
| cnt_mode | input | 1 | Enable block counting |
| blk_size | input | 10 | Block size in bytes (1..MAX_BLK) |
| blk_count | input | 16 | Block count loaded at start |
| desc_base | input | 32 | First descriptor address |
| err_int_en | input | 1 | Enable the error interrupt |
| dma_int_en | input | 1 | Enable the descriptor interrupt |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ready | input | 1 | Memory accepts/completes the access this cycle |
| mem_rdata | input | 8 | Memory read byte, valid with `mem_ready` |
| card_rd | output | 1 | Card read strobe, byte taken this cycle |
| card_rdata | input | 8 | Card read byte |
| card_wr | output | 1 | Card write strobe |
| card_wdata | output | 8 | Card write byte |
| status | output | 11 | [10] final block, [8] interrupt status, [2] mismatch, [1:0] fault state |
| busy | output | 1 | Walk in progress |
| paused | output | 1 | Halted on an interrupt descriptor |
| xfer_done | output | 1 | One-cycle pulse when a walk finishes |
| err_irq | output | 1 | Sticky error interrupt, cleared by start |
| dma_irq | output | 1 | Descriptor interrupt request |

## Verification
The assertions assume that `start` and continue requests arrive only while the engine is idle or paused. They also assume that `blk_size` stays between 1 and MAX_BLK and that the direction, mode and size inputs hold still during a walk. The stimulus sets every configuration input before each pulse and waits for `busy` to fall before it touches anything. It issues control writes only while the engine is idle or paused. The memory model inserts wait cycles in a fixed pattern, so the hold of request, address and write enable is exercised on every kind of access.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
   typedef enum logic [3:0] {
      S_IDLE, S_FETCH, S_DECODE, S_XFER, S_FILL,
      S_BEAT, S_DRAIN, S_BLK, S_FINISH, S_HALT
   } eng_st_t;

   localparam logic [1:0] ACT_TRAN  = 2'b10;
   localparam logic [1:0] ACT_LINK  = 2'b11;
   localparam logic [1:0] CODE_FDS  = 2'b01;
   localparam logic [1:0] CODE_XFER = 2'b11;
   localparam int         STAT_W    = 11;
   localparam int         DESC_LEN_W = 17;

   typedef struct packed {
      logic                  valid;
      logic                  last;
      logic                  irq;
      logic [1:0]            act;
      logic [DESC_LEN_W-1:0] len;
      logic [31:0]           addr;
   } desc_t;
endpackage

// File: rtl/sgdma_desc_unpack.sv
module sgdma_desc_unpack
   import sgdma_pkg::*;
(
   input  logic [63:0] raw,
   output desc_t       dn
);
   logic unused_ok;
   assign unused_ok = ^{raw[15:8], raw[7:6], raw[3]};

   always_comb begin
      dn.valid = raw[0];
      dn.last  = raw[1];
      dn.irq   = raw[2];
      dn.act   = raw[5:4];
      dn.len   = (raw[31:16] == 16'h0) ? DESC_LEN_W'(17'h10000) : {1'b0, raw[31:16]};
      dn.addr  = {raw[63:34], 2'b00};
   end
endmodule

// File: rtl/sgdma_stage_buf.sv
module sgdma_stage_buf #(
   parameter  int DEPTH = 512,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
   import sgdma_pkg::*;
#(
   parameter  int MAX_BLK = 512,
   parameter  int CNT_W   = 16,
   localparam int BSW     = $clog2(MAX_BLK) + 1,
   localparam int IW      = $clog2(MAX_BLK)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             ctl_wr,
   input  logic [10:0]      ctl_wdata,
   input  logic             dir_to_mem,
   input  logic             cnt_mode,
   input  logic [BSW-1:0]   blk_size,
   input  logic [CNT_W-1:0] blk_count,
   input  logic [31:0]      desc_base,
   input  logic             err_int_en,
   input  logic             dma_int_en,
   output logic             mem_req,
   output logic             mem_we,
   output logic [31:0]      mem_addr,
   output logic [7:0]       mem_wdata,
   input  logic             mem_ready,
   input  logic [7:0]       mem_rdata,
   output logic             card_rd,
   input  logic [7:0]       card_rdata,
   output logic             card_wr,
   output logic [7:0]       card_wdata,
   output logic [10:0]      status,
   output logic             busy,
   output logic             paused,
   output logic             xfer_done,
   output logic             err_irq,
   output logic             dma_irq
);
   if (MAX_BLK < 4 || (MAX_BLK & (MAX_BLK - 1)) != 0) begin : g_bad_blk
      $error("MAX_BLK must be a power of two of at least 4");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must lie in 1..32");
   end

   eng_st_t                st;
   logic [31:0]            ptr, daddr;
   logic [2:0]             fcnt;
   logic [63:0]            raw;
   desc_t                  dn;
   logic                   d_last, d_irq, d_link;
   logic [DESC_LEN_W-1:0]  rem;
   logic [BSW-1:0]         fill, ccnt;
   logic [CNT_W-1:0]       cnt;
   logic [1:0]             stcode;
   logic                   mism, intst, fin, err_flag;
   logic                   buf_we;
   logic [IW-1:0]          buf_wa, buf_ra;
   logic [7:0]             buf_wd, buf_rd;
   logic                   fill_last, ccnt_last, ended, bad_len;
   logic                   unused_ok;

   assign unused_ok = ^{ctl_wdata[10], ctl_wdata[7:0]};

   // descriptor byte lanes, one register per lane
   for (genvar g = 0; g < 8; g++) begin : g_lane
      logic [7:0] b;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) b <= '0;
         else if (st == S_FETCH && mem_ready && fcnt == 3'(g)) b <= mem_rdata;
      end
      assign raw[g*8 +: 8] = b;
   end

   sgdma_desc_unpack u_unpack (.raw(raw), .dn(dn));

   sgdma_stage_buf #(.DEPTH(MAX_BLK)) u_buf (
      .clk(clk), .we(buf_we), .waddr(buf_wa), .wdata(buf_wd),
      .raddr(buf_ra), .rdata(buf_rd)
   );

   assign fill_last = (fill == blk_size - 1'b1);
   assign ccnt_last = (ccnt == blk_size - 1'b1);
   assign ended     = (cnt_mode && cnt == '0) || d_last;
   assign bad_len   = (rem != '0) || (d_last && cnt_mode && cnt != '0) ||
                      (cnt_mode && cnt == '0 && !d_last);

   always_comb begin
      buf_we = 1'b0;
      buf_wa = fill[IW-1:0];
      buf_wd = mem_rdata;
      buf_ra = fill[IW-1:0];
      if (st == S_FILL) begin
         buf_we = 1'b1;
         buf_wa = ccnt[IW-1:0];
         buf_wd = card_rdata;
      end else if (st == S_BEAT && mem_ready && !dir_to_mem) begin
         buf_we = 1'b1;
      end
      if (st == S_DRAIN) buf_ra = ccnt[IW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE;  ptr <= '0;  daddr <= '0;  fcnt <= '0;
         d_last <= 1'b0;  d_irq <= 1'b0;  d_link <= 1'b0;
         rem <= '0;  fill <= '0;  ccnt <= '0;  cnt <= '0;
         stcode <= '0;  mism <= 1'b0;  intst <= 1'b0;  fin <= 1'b0;
         err_flag <= 1'b0;  xfer_done <= 1'b0;
      end else begin
         xfer_done <= 1'b0;
         if (ctl_wr && ctl_wdata[8]) intst <= 1'b0;
         unique case (st)
            S_IDLE, S_HALT: begin
               if (start) begin
                  ptr <= desc_base;  cnt <= blk_count;  fill <= '0;
                  stcode <= '0;  mism <= 1'b0;  fin <= 1'b0;  err_flag <= 1'b0;
                  fcnt <= '0;  st <= S_FETCH;
               end else if (st == S_HALT && ctl_wr && ctl_wdata[9]) begin
                  mism <= 1'b0;  fin <= 1'b0;  fcnt <= '0;  st <= S_FETCH;
               end
            end
            S_FETCH: if (mem_ready) begin
               fcnt <= fcnt + 3'd1;
               if (fcnt == 3'd7) st <= S_DECODE;
            end
            S_DECODE: begin
               d_last <= dn.last;  d_irq <= dn.irq;  d_link <= (dn.act == ACT_LINK);
               if (!dn.valid) begin
                  stcode <= CODE_FDS;
                  if (err_int_en) err_flag <= 1'b1;
                  st <= S_IDLE;
               end else begin
                  rem   <= (dn.act == ACT_TRAN) ? dn.len : '0;
                  daddr <= dn.addr;
                  st    <= S_XFER;
               end
            end
            S_XFER: begin
               if (rem == '0) st <= S_FINISH;
               else if (dir_to_mem && fill == '0) begin
                  ccnt <= '0;  st <= S_FILL;
               end else st <= S_BEAT;
            end
            S_FILL: begin
               ccnt <= ccnt + 1'b1;
               if (ccnt_last) st <= S_BEAT;
            end
            S_BEAT: if (mem_ready) begin
               daddr <= daddr + 32'd1;
               rem   <= rem - 1'b1;
               fill  <= fill + 1'b1;
               if (!fill_last) st <= S_XFER;
               else if (dir_to_mem) st <= S_BLK;
               else begin
                  ccnt <= '0;  st <= S_DRAIN;
               end
            end
            S_DRAIN: begin
               ccnt <= ccnt + 1'b1;
               if (ccnt_last) st <= S_BLK;
            end
            S_BLK: begin
               fill <= '0;
               if (cnt_mode) cnt <= cnt - 1'b1;
               st <= (cnt_mode && cnt == CNT_W'(1)) ? S_FINISH : S_XFER;
            end
            S_FINISH: begin
               ptr <= d_link ? daddr : ptr + 32'd8;
               if (ended) begin
                  if (bad_len) begin
                     mism <= 1'b1;  stcode <= CODE_XFER;
                     if (err_int_en) err_flag <= 1'b1;
                  end
                  fin <= 1'b1;  xfer_done <= 1'b1;  st <= S_IDLE;
               end else if (d_irq) begin
                  intst <= 1'b1;  st <= S_HALT;
               end else begin
                  fcnt <= '0;  st <= S_FETCH;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign mem_req    = (st == S_FETCH) || (st == S_BEAT);
   assign mem_we     = (st == S_BEAT) && dir_to_mem;
   assign mem_addr   = (st == S_FETCH) ? ptr + {29'd0, fcnt} : daddr;
   assign mem_wdata  = buf_rd;
   assign card_rd    = (st == S_FILL);
   assign card_wr    = (st == S_DRAIN);
   assign card_wdata = buf_rd;
   assign status     = {fin, 1'b0, intst, 5'd0, mism, stcode};
   assign busy       = (st != S_IDLE) && (st != S_HALT);
   assign paused     = (st == S_HALT);
   assign err_irq    = err_flag;
   assign dma_irq    = intst && dma_int_en;
endmodule

// File: rtl/sgdma_engine_chk.sv
module sgdma_engine_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        start,
   input logic        ctl_wr,
   input logic [1:0]  wr_bits,
   input logic        mem_req,
   input logic        mem_ready,
   input logic        mem_we,
   input logic [31:0] mem_addr,
   input logic        card_rd,
   input logic        card_wr,
   input logic        fin_bit,
   input logic        int_bit,
   input logic        busy,
   input logic        paused,
   input logic        xfer_done
);
   assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   assert_one_access_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(card_rd && card_wr) && !(mem_req && (card_rd || card_wr)));

   assert_done_final_R7: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> fin_bit);

   assert_final_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fin_bit) |-> xfer_done);

   assert_int_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_bit) |-> paused);

   assert_int_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && wr_bits[0] && !busy |=> !int_bit);

   assert_resume_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && wr_bits[1] && !paused && !busy && !start |=> !busy);
endmodule

bind sgdma_engine sgdma_engine_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .ctl_wr(ctl_wr),
   .wr_bits(ctl_wdata[9:8]), .mem_req(mem_req), .mem_ready(mem_ready),
   .mem_we(mem_we), .mem_addr(mem_addr), .card_rd(card_rd), .card_wr(card_wr),
   .fin_bit(status[10]), .int_bit(status[8]), .busy(busy), .paused(paused),
   .xfer_done(xfer_done)
);

// File: tb/sim_sgdma_engine.sv
`timescale 1ns/1ps
module sim_sgdma_engine;
   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 1'b0, ctl_wr = 1'b0;
   logic [10:0] ctl_wdata = '0;
   logic dir_to_mem = 1'b0, cnt_mode = 1'b0, err_int_en = 1'b1, dma_int_en = 1'b1;
   logic [9:0] blk_size = 10'd8;
   logic [15:0] blk_count = 16'd0;
   logic [31:0] desc_base = '0;
   logic mem_req, mem_we, mem_ready, card_rd, card_wr;
   logic [31:0] mem_addr;
   logic [7:0] mem_wdata, mem_rdata, card_rdata, card_wdata;
   logic [10:0] status;
   logic busy, paused, xfer_done, err_irq, dma_irq;

   always #2.5 clk = ~clk;

   sgdma_engine u0 (.*);

   // memory and card models
   logic [7:0] mem [0:4095];
   int tick = 0, cseq = 0, cycles = 0;
   assign mem_ready  = (tick % 3) != 2;
   assign mem_rdata  = mem[mem_addr[11:0]];
   function automatic logic [7:0] cbyte(input int n);
      return 8'((n * 37 + 5) & 255);
   endfunction
   assign card_rdata = cbyte(cseq);

   always @(posedge clk) begin
      tick <= tick + 1;
      cycles <= cycles + 1;
      if (card_rd) cseq <= cseq + 1;
      if (mem_req && mem_ready && mem_we) mem[mem_addr[11:0]] <= mem_wdata;
   end

   int n_chk = 0, n_err = 0, dones = 0;
   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // reference model state
   int mq_a[$];
   logic [7:0] mq_d[$], cq[$];
   int m_ptr, m_fill, m_cnt, m_cseq, m_out, m_cen, m_dir, m_bs;
   bit m_mism;
   logic [7:0] m_buf [0:511];

   task automatic model_walk();
      for (int k = 0; k < 64; k++) begin
         int attr, len, ad, act, rem;
         bit last;
         attr = mem[m_ptr & 4095];
         len  = {mem[(m_ptr + 3) & 4095], mem[(m_ptr + 2) & 4095]};
         ad   = {mem[(m_ptr + 7) & 4095], mem[(m_ptr + 6) & 4095],
                 mem[(m_ptr + 5) & 4095], mem[(m_ptr + 4) & 4095]} & 32'hFFFF_FFFC;
         if ((attr & 1) == 0) begin m_out = 0; m_mism = 0; return; end
         act = (attr >> 4) & 3;
         last = (attr & 2) != 0;
         rem = 0;
         if (act == 2) begin
            rem = (len == 0) ? 65536 : len;
            while (rem > 0) begin
               if (m_dir == 1) begin
                  if (m_fill == 0)
                     for (int i = 0; i < m_bs; i++) begin m_buf[i] = cbyte(m_cseq); m_cseq++; end
                  mq_a.push_back(ad); mq_d.push_back(m_buf[m_fill]);
               end else m_buf[m_fill] = mem[ad & 4095];
               m_fill++; ad++; rem--;
               if (m_fill == m_bs) begin
                  if (m_dir == 0) for (int i = 0; i < m_bs; i++) cq.push_back(m_buf[i]);
                  m_fill = 0;
                  if (m_cen != 0) begin
                     m_cnt--;
                     if (m_cnt == 0) break;
                  end
               end
            end
         end
         m_ptr = (act == 3) ? ad : m_ptr + 8;
         if ((m_cen != 0 && m_cnt == 0) || last) begin
            m_out = 1;
            m_mism = (rem != 0) || (last && m_cen != 0 && m_cnt != 0) ||
                     (m_cen != 0 && m_cnt == 0 && !last);
            return;
         end
         if ((attr & 4) != 0) begin m_out = 2; m_mism = 0; return; end
      end
   endtask

   // per-clock comparison against the model's expected streams
   always @(negedge clk) if (rst_n) begin
      if (xfer_done) dones++;
      if (mem_req && mem_ready && mem_we) begin
         if (mq_a.size() == 0) chk(0, "R4 unexpected memory write", mem_addr, 0);
         else begin
            int ea;
            logic [7:0] ed;
            ea = mq_a.pop_front(); ed = mq_d.pop_front();
            chk(mem_addr == ea, "R4 memory write address", mem_addr, ea);
            chk(mem_wdata == ed, "R4 memory write data", mem_wdata, ed);
         end
      end
      if (card_wr) begin
         if (cq.size() == 0) chk(0, "R5 unexpected card write", card_wdata, 0);
         else begin
            logic [7:0] ec;
            ec = cq.pop_front();
            chk(card_wdata == ec, "R5 card write data", card_wdata, ec);
         end
      end
   end

   task automatic put_desc(input int at, input int attr, input int len, input int ad);
      mem[at] = 8'(attr); mem[at + 1] = 8'h00;
      mem[at + 2] = 8'(len); mem[at + 3] = 8'(len >> 8);
      for (int i = 0; i < 4; i++) mem[at + 4 + i] = 8'(ad >> (8 * i));
   endtask

   task automatic ctl(input logic [10:0] v);
      @(posedge clk); #1 ctl_wr = 1'b1; ctl_wdata = v;
      @(posedge clk); #1 ctl_wr = 1'b0; ctl_wdata = '0;
   endtask

   task automatic wait_idle();
      int g = 0;
      do begin @(negedge clk); g++; end while (busy && g < 30000);
   endtask

   // resume=0: start a new walk; resume=1: continue a paused walk
   task automatic run(input bit resume, input string req);
      int d0;
      d0 = dones;
      if (!resume) begin
         m_ptr = desc_base; m_fill = 0; m_cnt = blk_count;
         m_cen = cnt_mode; m_dir = dir_to_mem; m_bs = blk_size;
      end
      m_cseq = cseq;
      model_walk();
      if (resume) ctl(11'h200);
      else begin
         @(posedge clk); #1 start = 1'b1;
         @(posedge clk); #1 start = 1'b0;
      end
      wait_idle();
      @(negedge clk);
      chk(status[10] == (m_out == 1), {req, " final bit"}, status[10], m_out == 1);
      chk(status[2] == m_mism, {req, " mismatch bit"}, status[2], m_mism);
      chk(status[1:0] == (m_out == 0 ? 2'b01 : (m_mism ? 2'b11 : 2'b00)),
          {req, " fault state"}, status[1:0], m_out == 0 ? 1 : (m_mism ? 3 : 0));
      chk(paused == (m_out == 2), {req, " paused"}, paused, m_out == 2);
      chk(dones - d0 == (m_out == 1 ? 1 : 0), {req, " done pulses"}, dones - d0, m_out == 1);
      chk(mq_a.size() == 0 && cq.size() == 0, {req, " missing beats"},
          mq_a.size() + cq.size(), 0);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 13 + 1) & 255);
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(status == '0 && !busy && !paused && !mem_req && !card_rd && !card_wr
          && !err_irq && !dma_irq, "R7 reset state", status, 0);

      // R1 R4 R7: single end descriptor, two full blocks to memory
      put_desc(12'h000, 8'h23, 16, 32'h400);
      dir_to_mem = 1; cnt_mode = 1; blk_size = 8; blk_count = 2; desc_base = 32'h000;
      run(0, "R1 R4 R7 basic read");

      // R4 carry-over and R2 alignment (0x503 used as 0x500)
      put_desc(12'h040, 8'h21, 5, 32'h503);
      put_desc(12'h048, 8'h23, 11, 32'h600);
      desc_base = 32'h040;
      run(0, "R2 R4 carry");

      // R5 R6: link, no-op, then write direction transfer
      put_desc(12'h080, 8'h31, 0, 32'h0C0);
      put_desc(12'h0C0, 8'h01, 3, 32'h0);
      put_desc(12'h0C8, 8'h23, 8, 32'h700);
      dir_to_mem = 0; blk_size = 4; blk_count = 2; desc_base = 32'h080;
      run(0, "R5 R6 write with link");

      // R8: end flag with count still nonzero
      put_desc(12'h100, 8'h23, 8, 32'h800);
      dir_to_mem = 1; blk_size = 4; blk_count = 3; desc_base = 32'h100;
      run(0, "R8 end before count");
      chk(err_irq == 1'b1, "R8 error interrupt", err_irq, 1);

      // R2 R8: zero length means 65536, count exhausted with bytes left
      put_desc(12'h140, 8'h21, 0, 32'h900);
      blk_size = 8; blk_count = 1; desc_base = 32'h140;
      run(0, "R2 R8 count exhausted");

      // R3: invalid descriptor after a good one
      put_desc(12'h180, 8'h21, 4, 32'hA00);
      put_desc(12'h188, 8'h20, 4, 32'hA40);
      cnt_mode = 0; blk_size = 4; desc_base = 32'h180;
      run(0, "R3 invalid");
      chk(err_irq == 1'b1, "R3 error interrupt", err_irq, 1);

      // R9 R10 R11: interrupt halt, ignored set attempt, resume, clear
      put_desc(12'h1C0, 8'h25, 4, 32'hB00);
      put_desc(12'h1C8, 8'h23, 4, 32'hB10);
      desc_base = 32'h1C0;
      run(0, "R9 halt");
      chk(status[8] == 1'b1 && dma_irq == 1'b1, "R9 interrupt status", {status[8], dma_irq}, 3);
      chk(err_irq == 1'b0, "R9 no error", err_irq, 0);
      ctl(11'h400);
      @(negedge clk);
      chk(status[10] == 1'b0 && paused, "R11 no software set of final bit", status[10], 0);
      run(1, "R10 resume");
      chk(status[8] == 1'b1, "R11 interrupt status kept", status[8], 1);
      ctl(11'h100);
      @(negedge clk);
      chk(status[8] == 1'b0 && dma_irq == 1'b0, "R11 interrupt status cleared", status[8], 0);

      // R10: continue while idle is ignored
      ctl(11'h200);
      repeat (3) @(negedge clk);
      chk(!busy && !mem_req && status[10] == 1'b1, "R10 continue ignored when idle",
          {busy, mem_req}, 0);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      wait (cycles > 190000);
      chk(0, "watchdog expired", cycles, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule